// File: doc/BRIEF.md
# Phase-Selectable Peak and Period Detector

This block watches three phases of signed voltage and current samples that arrive together under one valid strobe. It measures the line period on one chosen phase. It also tracks the largest voltage magnitude and the largest current magnitude seen on a chosen set of phases. Each voltage sample's sign is compared with the previous valid sample's sign on the same phase to find zero crossings. The crossings drive both measurements.

The period path counts clock cycles between consecutive negative-to-positive crossings on the phase named by a two-bit selector. The peak path tracks magnitudes over a window. The window closes after a programmed number of zero crossings, counted across all phases enabled by a three-bit mask. Enabling more phases therefore closes the window sooner in time. When the window closes, the peaks and the phase that produced each one are latched, the trackers restart and a one-cycle done pulse is raised.

Both selectors sit in configuration registers that are written by a one-cycle load strobe. The window length is a live input.

Two state machines do the control:
- The period machine has two states. `P_ARM` waits for the first rising crossing; the transition *arm→meas* happens on that crossing. `P_MEAS` counts cycles; its transition *meas→meas* publishes the count on each rising crossing. The transition *restart→arm* happens on a configuration load.
- The peak machine has two states. `K_HOLD` is entered when the mask is empty, and does nothing. `K_TRACK` tracks peaks and counts crossings; its transition *track→track* closes the window. A configuration load takes the transition *load→hold* when the new mask is zero, and *load→track* otherwise.

Top module: `peak_period_det`

## Requirements
- R1: After reset, the period, both peaks, both phase indices and the done pulse are zero. The peak mask is 3'b111 (all phases enabled) and the period selector is 2'b00 (phase A).
- R2: Period selector 2'b00 picks phase A, 2'b01 picks phase B and 2'b10 picks phase C. Within a sample vector, phase p occupies bits [p*DW +: DW], with A=0, B=1 and C=2.
- R3: Period selector 2'b11 behaves exactly like 2'b00 and measures phase A.
- R4: The period output equals the number of clock cycles between two consecutive negative-to-positive crossings on the selected phase. It changes only on such a crossing. The first crossing after reset or after a configuration load only arms the measurement.
- R5: A zero crossing occurs on a phase when a valid voltage sample's sign bit differs from the sign bit of that phase's previous valid sample. The first valid sample after reset never counts as a crossing.
- R6: The peak window closes on the sample whose crossings, added to those counted earlier in the window from enabled phases, reach the window length. A length of 0 acts as 1. win_done is high for the one cycle after that sample.
- R7: Peaks are compared by absolute value and reported as unsigned magnitudes. A later sample replaces the peak only if it is strictly greater. Within one sample, the lowest phase wins a tie. On window close, the peak and its phase index (0=A, 1=B, 2=C) are latched with the closing sample included, and the trackers restart from zero.
- R8: The mask bit for a phase (bit 0=A, bit 1=B, bit 2=C) enables that phase for both voltage and current peak capture and for window crossing counting. Disabled phases have no effect.
- R9: With an all-zero mask, no window closes and the latched peaks and phase indices hold their values.
- R10: A cycle with cfg_wr high loads the selector and mask, re-arms the period measurement and restarts the peak window. The samples of that cycle do not count toward peaks or crossings, but they do update each phase's remembered sign.
- R11: The period counter saturates at 2^PW-1, and a longer interval reports that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | All six samples valid this cycle |
| v_smp | input | 3*DW | Signed voltage samples, phase p at [p*DW +: DW] |
| i_smp | input | 3*DW | Signed current samples, same packing |
| cfg_wr | input | 1 | Load selector and mask, restart measurements |
| cfg_per_sel | input | 2 | Period source selector |
| cfg_pk_mask | input | 3 | Peak phase enable mask |
| win_len | input | CW | Peak window length in zero crossings |
| period | output | PW | Last measured period in clock cycles |
| v_peak | output | DW | Latched voltage peak magnitude |
| v_peak_ph | output | 2 | Phase index of voltage peak |
| i_peak | output | DW | Latched current peak magnitude |
| i_peak_ph | output | 2 | Phase index of current peak |
| win_done | output | 1 | One-cycle pulse when the peak window closes |

## Verification
A stale remembered sign or a bad crossing count shows up as a win_done pulse on the wrong sample, one cycle after that sample. A tracker that is not cleared, or is compared on signed values, shows up as a wrong magnitude or phase index at the next window close. A wrong period state, or the wrong source phase, shows up as a wrong period value at the second rising crossing after arming. The bench runs a cycle-level reference model beside the block and compares every output every cycle. So any divergence is reported in the cycle the outputs first differ.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    localparam int NPH = 3;
    localparam int PHW = 2;

    typedef enum logic {P_ARM, P_MEAS} per_state_t;
    typedef enum logic {K_HOLD, K_TRACK} pk_state_t;
endpackage

// File: rtl/ppd_zc.sv
module ppd_zc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [DW-1:0] smp,
    output logic          zc,
    output logic          rise
);
    logic prev_neg;
    logic seen;
    logic now_neg;

    assign now_neg = smp[DW-1];
    assign zc      = valid && seen && (now_neg != prev_neg);
    assign rise    = valid && seen && prev_neg && !now_neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_neg <= 1'b0;
            seen     <= 1'b0;
        end else if (valid) begin
            prev_neg <= now_neg;
            seen     <= 1'b1;
        end
    end
endmodule

// File: rtl/ppd_period.sv
module ppd_period
    import ppd_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          rise,
    output logic [PW-1:0] period
);
    localparam logic [PW-1:0] CMAX = {PW{1'b1}};

    per_state_t    state, nstate;
    logic [PW-1:0] cnt;

    always_comb begin
        nstate = state;
        unique case (state)
            P_ARM:  if (rise) nstate = P_MEAS;
            P_MEAS: nstate = P_MEAS;
        endcase
        if (restart) nstate = P_ARM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_ARM;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            period <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else begin
            unique case (state)
                P_ARM: if (rise) cnt <= PW'(1);
                P_MEAS: begin
                    if (rise) begin
                        period <= cnt;
                        cnt    <= PW'(1);
                    end else if (cnt != CMAX) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ppd_peak.sv
module ppd_peak
    import ppd_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [NPH-1:0]    mask,
    input  logic [NPH-1:0]    new_mask,
    input  logic              valid,
    input  logic [NPH-1:0]    zc,
    input  logic [NPH*DW-1:0] v_smp,
    input  logic [NPH*DW-1:0] i_smp,
    input  logic [CW-1:0]     win_len,
    output logic [DW-1:0]     v_peak,
    output logic [PHW-1:0]    v_ph,
    output logic [DW-1:0]     i_peak,
    output logic [PHW-1:0]    i_ph,
    output logic              done
);
    localparam int XW = CW + 2;

    pk_state_t      state, nstate;
    logic [DW-1:0]  v_abs [NPH];
    logic [DW-1:0]  i_abs [NPH];
    logic [DW-1:0]  v_trk, i_trk, v_best, i_best;
    logic [PHW-1:0] v_tph, i_tph, v_bph, i_bph;
    logic [XW-1:0]  x_cnt, n_x, x_sum, wl_eff;
    logic           win_end;

    for (genvar p = 0; p < NPH; p++) begin : g_abs
        assign v_abs[p] = v_smp[p*DW+DW-1] ? (~v_smp[p*DW +: DW] + 1'b1) : v_smp[p*DW +: DW];
        assign i_abs[p] = i_smp[p*DW+DW-1] ? (~i_smp[p*DW +: DW] + 1'b1) : i_smp[p*DW +: DW];
    end

    always_comb begin
        v_best = v_trk;
        v_bph  = v_tph;
        i_best = i_trk;
        i_bph  = i_tph;
        for (int p = 0; p < NPH; p++) begin
            if (valid && mask[p] && (v_abs[p] > v_best)) begin
                v_best = v_abs[p];
                v_bph  = PHW'(p);
            end
            if (valid && mask[p] && (i_abs[p] > i_best)) begin
                i_best = i_abs[p];
                i_bph  = PHW'(p);
            end
        end
    end

    assign n_x     = XW'($countones(zc & mask));
    assign x_sum   = x_cnt + n_x;
    assign wl_eff  = (win_len == '0) ? XW'(1) : XW'(win_len);
    assign win_end = (state == K_TRACK) && !restart && (n_x != '0) && (x_sum >= wl_eff);

    always_comb begin
        nstate = state;
        unique case (state)
            K_HOLD:  nstate = K_HOLD;
            K_TRACK: nstate = K_TRACK;
        endcase
        if (restart) nstate = (new_mask == '0) ? K_HOLD : K_TRACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= K_TRACK;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_trk  <= '0;
            v_tph  <= '0;
            i_trk  <= '0;
            i_tph  <= '0;
            x_cnt  <= '0;
            v_peak <= '0;
            v_ph   <= '0;
            i_peak <= '0;
            i_ph   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (restart) begin
                v_trk <= '0;
                v_tph <= '0;
                i_trk <= '0;
                i_tph <= '0;
                x_cnt <= '0;
            end else if (state == K_TRACK) begin
                if (win_end) begin
                    v_peak <= v_best;
                    v_ph   <= v_bph;
                    i_peak <= i_best;
                    i_ph   <= i_bph;
                    done   <= 1'b1;
                    v_trk  <= '0;
                    v_tph  <= '0;
                    i_trk  <= '0;
                    i_tph  <= '0;
                    x_cnt  <= '0;
                end else begin
                    v_trk <= v_best;
                    v_tph <= v_bph;
                    i_trk <= i_best;
                    i_tph <= i_bph;
                    x_cnt <= x_sum;
                end
            end
        end
    end
endmodule

// File: rtl/peak_period_det.sv
module peak_period_det
    import ppd_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int PW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [3*DW-1:0]   v_smp,
    input  logic [3*DW-1:0]   i_smp,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_per_sel,
    input  logic [2:0]        cfg_pk_mask,
    input  logic [CW-1:0]     win_len,
    output logic [PW-1:0]     period,
    output logic [DW-1:0]     v_peak,
    output logic [1:0]        v_peak_ph,
    output logic [DW-1:0]     i_peak,
    output logic [1:0]        i_peak_ph,
    output logic              win_done
);
    logic [1:0]     sel_q;
    logic [NPH-1:0] mask_q;
    logic [NPH-1:0] zc, rise;
    logic           rise_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 2'b00;
            mask_q <= {NPH{1'b1}};
        end else if (cfg_wr) begin
            sel_q  <= cfg_per_sel;
            mask_q <= cfg_pk_mask;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_zc
        ppd_zc #(.DW(DW)) u_zc (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (smp_valid),
            .smp   (v_smp[p*DW +: DW]),
            .zc    (zc[p]),
            .rise  (rise[p])
        );
    end

    always_comb begin
        unique case (sel_q)
            2'b01:   rise_sel = rise[1];
            2'b10:   rise_sel = rise[2];
            default: rise_sel = rise[0];
        endcase
    end

    ppd_period #(.PW(PW)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .rise    (rise_sel),
        .period  (period)
    );

    ppd_peak #(.DW(DW), .CW(CW)) u_pk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_wr),
        .mask     (mask_q),
        .new_mask (cfg_pk_mask),
        .valid    (smp_valid),
        .zc       (zc),
        .v_smp    (v_smp),
        .i_smp    (i_smp),
        .win_len  (win_len),
        .v_peak   (v_peak),
        .v_ph     (v_peak_ph),
        .i_peak   (i_peak),
        .i_ph     (i_peak_ph),
        .done     (win_done)
    );
endmodule

// File: rtl/ppd_chk.sv
module ppd_chk #(
    parameter int DW = 16,
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          cfg_wr,
    input logic [2:0]    mask_q,
    input logic          win_done,
    input logic [PW-1:0] period,
    input logic [DW-1:0] v_peak,
    input logic [DW-1:0] i_peak,
    input logic [1:0]    v_peak_ph,
    input logic [1:0]    i_peak_ph
);
    // R6: a window can close only on a valid sample outside a load cycle
    p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ($past(smp_valid) && !$past(cfg_wr)));

    // R9: empty mask never closes a window and holds the peaks
    p_mask_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 3'b000) |=> (!win_done && $stable(v_peak) && $stable(i_peak)));

    // R4: the period moves only after a valid sample
    p_period_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(period));

    // R7: latched peaks change only together with the done pulse
    p_peak_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(v_peak) || !$stable(i_peak)) |-> win_done);

    // R7: phase indices stay within A..C
    p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_peak_ph != 2'd3) && (i_peak_ph != 2'd3));
endmodule

bind peak_period_det ppd_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .cfg_wr    (cfg_wr),
    .mask_q    (mask_q),
    .win_done  (win_done),
    .period    (period),
    .v_peak    (v_peak),
    .i_peak    (i_peak),
    .v_peak_ph (v_peak_ph),
    .i_peak_ph (i_peak_ph)
);

// File: tb/peak_period_det_test.sv
module peak_period_det_test;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int PW   = 10;
    localparam int PMAX = (1 << PW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [3*DW-1:0] v_smp = '0;
    logic [3*DW-1:0] i_smp = '0;
    logic            cfg_wr = 1'b0;
    logic [1:0]      cfg_per_sel = 2'b00;
    logic [2:0]      cfg_pk_mask = 3'b000;
    logic [CW-1:0]   win_len = '0;
    logic [PW-1:0]   period;
    logic [DW-1:0]   v_peak, i_peak;
    logic [1:0]      v_peak_ph, i_peak_ph;
    logic            win_done;

    int tests = 0;
    int fails = 0;

    // reference model state
    int m_pneg [3];
    int m_seen [3];
    int m_parm = 1, m_cnt = 0, m_period = 0;
    int m_vtrk = 0, m_vtph = 0, m_itrk = 0, m_itph = 0, m_xc = 0;
    int m_hold = 0, m_mask = 7, m_sel = 0;
    int m_vpk = 0, m_vph = 0, m_ipk = 0, m_iph = 0, m_done = 0;

    peak_period_det #(.DW(DW), .CW(CW), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .v_smp(v_smp), .i_smp(i_smp),
        .cfg_wr(cfg_wr), .cfg_per_sel(cfg_per_sel), .cfg_pk_mask(cfg_pk_mask),
        .win_len(win_len), .period(period), .v_peak(v_peak), .v_peak_ph(v_peak_ph),
        .i_peak(i_peak), .i_peak_ph(i_peak_ph), .win_done(win_done)
    );

    always #2 clk = ~clk;

    function automatic int absv(input int x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input int vld, input int v[3], input int ci[3], input int wr,
                         input int s, input int m);
        int zc[3], rs[3], selp, bv, bp, bi, bip, n, wl;
        for (int p = 0; p < 3; p++) begin
            int sg = (v[p] < 0) ? 1 : 0;
            zc[p] = (vld != 0 && m_seen[p] != 0 && sg != m_pneg[p]) ? 1 : 0;
            rs[p] = (zc[p] != 0 && m_pneg[p] != 0) ? 1 : 0;
            if (vld != 0) begin
                m_pneg[p] = sg;
                m_seen[p] = 1;
            end
        end
        selp = (m_sel == 1) ? 1 : (m_sel == 2) ? 2 : 0;
        m_done = 0;
        if (wr != 0) begin
            m_parm = 1; m_cnt = 0;
            m_vtrk = 0; m_vtph = 0; m_itrk = 0; m_itph = 0; m_xc = 0;
            m_mask = m; m_sel = s; m_hold = (m == 0) ? 1 : 0;
        end else begin
            if (m_parm != 0) begin
                if (rs[selp] != 0) begin m_parm = 0; m_cnt = 1; end
            end else if (rs[selp] != 0) begin
                m_period = m_cnt; m_cnt = 1;
            end else if (m_cnt < PMAX) begin
                m_cnt++;
            end
            if (m_hold == 0) begin
                bv = m_vtrk; bp = m_vtph; bi = m_itrk; bip = m_itph; n = 0;
                for (int p = 0; p < 3; p++) begin
                    if (vld != 0 && m[0] == 1'b0) begin end
                    if (vld != 0 && ((m_mask >> p) & 1) != 0) begin
                        if (absv(v[p]) > bv) begin bv = absv(v[p]); bp = p; end
                        if (absv(ci[p]) > bi) begin bi = absv(ci[p]); bip = p; end
                    end
                    if (zc[p] != 0 && ((m_mask >> p) & 1) != 0) n++;
                end
                wl = (int'(win_len) == 0) ? 1 : int'(win_len);
                if (n > 0 && m_xc + n >= wl) begin
                    m_vpk = bv; m_vph = bp; m_ipk = bi; m_iph = bip; m_done = 1;
                    m_vtrk = 0; m_vtph = 0; m_itrk = 0; m_itph = 0; m_xc = 0;
                end else begin
                    m_vtrk = bv; m_vtph = bp; m_itrk = bi; m_itph = bip; m_xc = m_xc + n;
                end
            end
        end
    endtask

    task automatic cyc(input int vld, input int va, input int vb, input int vc,
                       input int ia, input int ib, input int ic,
                       input int wr = 0, input int s = 0, input int m = 0);
        int v[3], ci[3];
        v[0] = va; v[1] = vb; v[2] = vc;
        ci[0] = ia; ci[1] = ib; ci[2] = ic;
        smp_valid = (vld != 0);
        cfg_wr = (wr != 0);
        cfg_per_sel = 2'(s);
        cfg_pk_mask = 3'(m);
        for (int p = 0; p < 3; p++) begin
            v_smp[p*DW +: DW] = DW'(v[p]);
            i_smp[p*DW +: DW] = DW'(ci[p]);
        end
        model(vld, v, ci, wr, s, m);
        @(posedge clk);
        @(negedge clk);
        chk("R4 period", int'(period), m_period);
        chk("R6 win_done", int'(win_done), m_done);
        chk("R7 v_peak", int'(v_peak), m_vpk);
        chk("R7 v_peak_ph", int'(v_peak_ph), m_vph);
        chk("R8 i_peak", int'(i_peak), m_ipk);
        chk("R8 i_peak_ph", int'(i_peak_ph), m_iph);
    endtask

    function automatic int rnd_smp();
        return int'($urandom % 65536) - 32768;
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt_done, sg;
        void'($urandom(32'd1234));
        for (int p = 0; p < 3; p++) begin m_pneg[p] = 0; m_seen[p] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 period", int'(period), 0);
        chk("R1 v_peak", int'(v_peak), 0);
        chk("R1 i_peak", int'(i_peak), 0);
        chk("R1 win_done", int'(win_done), 0);
        chk("R1 ph", int'(v_peak_ph) + int'(i_peak_ph), 0);
        rst_n = 1'b1;
        win_len = CW'(1);
        @(negedge clk);

        // R5: first sample after reset is no crossing
        cyc(1, -5, -5, -5, 1, 1, 1);
        chk("R5 first sample", int'(win_done), 0);
        cyc(1, 5, -5, -5, 2, 2, 2);
        chk("R5 sign change", int'(win_done), 1);
        chk("R7 tie earlier", int'(v_peak_ph), 0);
        // R1: default mask has phase C enabled
        cyc(1, 5, -5, 9, 2, 2, 2);
        chk("R1 default mask", int'(win_done), 1);
        chk("R1 default mask peak", int'(v_peak), 9);

        // R2: selector 01 picks phase B, half period 5 samples
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 7);
        for (int k = 0; k < 40; k++) cyc(1, 1, ((k / 5) % 2 != 0) ? 3 : -3, 1, 0, 0, 0);
        chk("R2 phase B period", int'(period), 10);

        // R3: reserved code 11 measures phase A
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 3, 7);
        for (int k = 0; k < 40; k++)
            cyc(1, ((k / 4) % 2 != 0) ? 3 : -3, ((k / 6) % 2 != 0) ? 3 : -3, 1, 0, 0, 0);
        chk("R3 reserved selector", int'(period), 8);

        // R6: window of 3 crossings on phase A only
        win_len = CW'(3);
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0, 1);
        cnt_done = 0;
        for (int k = 0; k < 9; k++) begin
            cyc(1, (k % 2 == 0) ? -1 : 1, 1, 1, 0, 0, 0);
            cnt_done += int'(win_done);
        end
        chk("R6 single phase window", cnt_done, 3);
        // R6: three phases share the counter
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0, 7);
        cnt_done = 0;
        for (int k = 0; k < 4; k++) begin
            sg = (k % 2 == 0) ? -1 : 1;
            cyc(1, sg, sg, sg, 0, 0, 0);
            cnt_done += int'(win_done);
        end
        chk("R6 shared window", cnt_done, 4);

        // R7: magnitude compare, lowest phase wins a tie
        win_len = CW'(1);
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0, 7);
        cyc(1, -100, 100, 50, 5, -7, 7);
        chk("R7 v magnitude", int'(v_peak), 100);
        chk("R7 v tie phase", int'(v_peak_ph), 0);
        chk("R7 i magnitude", int'(i_peak), 7);
        chk("R7 i tie phase", int'(i_peak_ph), 1);

        // R8: only phase C enabled for both peaks
        cyc(1, 1, 1, 10, 0, 0, 0, 1, 0, 4);
        cyc(1, -30000, 0, -20, 9000, 0, -3);
        chk("R8 v from C", int'(v_peak), 20);
        chk("R8 i from C", int'(i_peak), 3);
        chk("R8 i phase", int'(i_peak_ph), 2);

        // R10: load cycle samples ignored
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0, 7);
        cyc(1, -30000, -30000, -30000, 0, 0, 0, 1, 0, 7);
        chk("R10 load cycle no done", int'(win_done), 0);
        cyc(1, 5, 5, 5, 1, 1, 1);
        chk("R10 restart peak", int'(v_peak), 5);

        // R9: empty mask holds
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        cnt_done = 0;
        for (int k = 0; k < 10; k++) begin
            sg = (k % 2 == 0) ? -20000 : 20000;
            cyc(1, sg, sg, sg, sg, sg, sg);
            cnt_done += int'(win_done);
        end
        chk("R9 no done", cnt_done, 0);
        chk("R9 hold peak", int'(v_peak), 5);

        // R11: saturation of the period counter
        cyc(1, -1, 1, 1, 0, 0, 0, 1, 0, 7);
        cyc(1, 1, 1, 1, 0, 0, 0);
        cyc(1, -1, 1, 1, 0, 0, 0);
        for (int k = 0; k < 1100; k++) cyc(0, -1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R11 saturated", int'(period), PMAX);
        cyc(1, -1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R11 after saturation", int'(period), 2);

        // random phase: R2 R4 R6 R7 R8 against the model
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 200 == 0) begin
                win_len = CW'($urandom % 7);
                cyc(int'($urandom % 2), rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(),
                    rnd_smp(), 1, int'($urandom % 4), int'($urandom % 8));
            end else begin
                cyc(($urandom % 4) != 0 ? 1 : 0, rnd_smp(), rnd_smp(), rnd_smp(),
                    rnd_smp(), rnd_smp(), rnd_smp());
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule